// File: doc/BRIEF.md
# Weak-Ordering Memory Fence Unit

This unit sits between an in-order issue stage and a memory system that may finish data accesses in any order. Each operation offered for issue is tagged as a plain data access (load or store) or as one of three synchronization kinds: acquire, release, or full sync. The unit counts data accesses that have issued but not completed. It also keeps a one-bit record of an outstanding synchronization operation. From these it decides, cycle by cycle, whether the offered operation may issue.

A mode input selects between two policies. In weak-ordering mode every synchronization is a two-sided fence. It waits for all earlier data accesses to drain, and nothing issues behind it until it completes. In release-consistency mode the fence is split. A release waits for earlier data, but later data may pass it. An acquire does not wait for earlier data, but nothing issues behind it until it completes. A full sync keeps the two-sided behaviour. Memory reports each finished data access with `data_done` and each finished synchronization with `sync_done`.

Top module: `mem_fence_unit`

## Requirements
- R1: An accepted data operation raises the outstanding count by one. A `data_done` pulse lowers it by one. A full sync in weak mode becomes ready exactly when the count returns to zero.
- R2: With 15 data operations outstanding, a further data operation is not ready.
- R3: A `data_done` pulse while the count is zero drives `cmp_err` high for exactly the following cycle. The count stays at zero and does not wrap.
- R4: In weak mode (`rc_mode`=0), any synchronization kind (`op_kind` 01, 10 or 11) is ready only when no data operation is outstanding.
- R5: In weak mode, a data operation (`op_kind`=00) is not ready while a synchronization is outstanding.
- R6: In either mode, no synchronization is ready while another synchronization is outstanding, so synchronizations stay in program order.
- R7: In release mode (`rc_mode`=1), a release (`op_kind`=10) is ready only when no data operation is outstanding.
- R8: In release mode, data operations stay ready while only a release is outstanding, subject to R2.
- R9: In release mode, no operation is ready while an acquire (`op_kind`=01) is outstanding.
- R10: In release mode, an acquire is ready with data operations still outstanding, provided no synchronization is outstanding.
- R11: In release mode, a full sync (`op_kind`=11) waits for both the data count and any outstanding synchronization to clear.
- R12: `stall` is high exactly when `op_valid` is high and `op_ready` is low.
- R13: After reset the count is zero, no synchronization is outstanding, and `cmp_err` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rc_mode | input | 1 | 0 selects weak ordering, 1 selects release consistency |
| op_valid | input | 1 | Issue stage offers an operation |
| op_kind | input | 2 | 00 data, 01 acquire, 10 release, 11 full sync |
| op_ready | output | 1 | Offered operation may issue this cycle |
| stall | output | 1 | Offered operation is held back |
| data_done | input | 1 | One data operation completed |
| sync_done | input | 1 | The outstanding synchronization completed |
| cmp_err | output | 1 | Data completion arrived with nothing outstanding |

## Verification
Each test case pairs a mode, an outstanding data count from 0 to 15, and an outstanding synchronization kind: none, acquire, release or full sync. In every case, all four operation kinds are offered and readiness is compared with the ordering rules. This separates the two-sided fence of weak mode from the split acquire and release fences, and it shows that an acquire can pass pending data while a release cannot. Draining the count one completion at a time shows that the fence lifts exactly at zero. A further completion at zero exercises the error pulse and shows the counter does not wrap.

// File: rtl/mem_fence_unit.sv
module mem_fence_unit #(
  parameter int CNT_W = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rc_mode,
  input  logic       op_valid,
  input  logic [1:0] op_kind,
  output logic       op_ready,
  output logic       stall,
  input  logic       data_done,
  input  logic       sync_done,
  output logic       cmp_err
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [1:0] K_DATA = 2'b00;
  localparam logic [1:0] K_ACQ  = 2'b01;
  localparam logic [1:0] K_REL  = 2'b10;

  logic [CNT_W-1:0] cnt;
  logic             sync_busy;
  logic [1:0]       sync_kind;

  wire is_data = (op_kind == K_DATA);
  wire empty   = (cnt == '0);
  wire full    = (cnt == CNT_MAX);
  wire data_ok = !full && (!sync_busy || (rc_mode && sync_kind == K_REL));
  wire sync_ok = !sync_busy && (empty || (rc_mode && op_kind == K_ACQ));
  wire fire    = op_valid && op_ready;
  wire inc     = fire && is_data;
  wire dec     = data_done && !empty;

  assign op_ready = is_data ? data_ok : sync_ok;
  assign stall    = op_valid && !op_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt       <= '0;
      sync_busy <= 1'b0;
      sync_kind <= K_DATA;
      cmp_err   <= 1'b0;
    end else begin
      cnt     <= cnt + CNT_W'(inc) - CNT_W'(dec);
      cmp_err <= data_done && empty;
      if (fire && !is_data) begin
        sync_busy <= 1'b1;
        sync_kind <= op_kind;
      end else if (sync_done) begin
        sync_busy <= 1'b0;
      end
    end
  end

  assert_count_up_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_ready && is_data && !data_done) |=> (cnt == $past(cnt) + 1'b1));

  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CNT_MAX && !data_done) |=> (cnt == CNT_MAX));

  assert_no_underflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (data_done && cnt == '0 && !(op_valid && op_ready && is_data)) |=> (cnt == '0 && cmp_err));

  assert_weak_drain_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_ready && !is_data && !rc_mode) |-> (cnt == '0));

  assert_sync_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_ready && !is_data) |-> !sync_busy);

  assert_acq_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rc_mode && sync_busy && sync_kind == K_ACQ) |-> !(op_valid && op_ready));

  assert_stall_hs_R12: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (op_valid && !(op_valid && op_ready)));
endmodule

// File: tb/mem_fence_unit_tb.sv
module mem_fence_unit_tb;
  localparam int CLK_P = 10;
  localparam int MAXC  = 15;

  logic clk = 1'b0, rst_n = 1'b0, rc_mode = 1'b0, op_valid = 1'b0;
  logic [1:0] op_kind = 2'b00;
  logic data_done = 1'b0, sync_done = 1'b0;
  logic op_ready, stall, cmp_err;
  int checks = 0, errors = 0;
  bit finished = 0;

  int m_cnt;
  bit m_busy;
  int m_kind;

  always #(CLK_P/2) clk = ~clk;

  mem_fence_unit #(.CNT_W(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .rc_mode(rc_mode), .op_valid(op_valid),
    .op_kind(op_kind), .op_ready(op_ready), .stall(stall),
    .data_done(data_done), .sync_done(sync_done), .cmp_err(cmp_err));

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; op_valid = 1'b0; data_done = 1'b0; sync_done = 1'b0;
    cyc(); cyc();
    rst_n = 1'b1;
    m_cnt = 0; m_busy = 0; m_kind = 0;
  endtask

  task automatic probe(int k, logic exp, string tag);
    op_valid = 1'b1; op_kind = 2'(k);
    #1;
    chk(tag, op_ready, exp);
    chk("R12 stall", stall, !exp);
    op_valid = 1'b0;
    #1;
  endtask

  task automatic issue(int k);
    op_valid = 1'b1; op_kind = 2'(k);
    cyc();
    op_valid = 1'b0;
  endtask

  function automatic logic exp_rdy(int mode, int k);
    if (k == 0) return (m_cnt < MAXC) && (!m_busy || (mode == 1 && m_kind == 2));
    if (m_busy) return 1'b0;
    if (mode == 1 && k == 1) return 1'b1;
    return m_cnt == 0;
  endfunction

  function automatic string tag_of(int mode, int k);
    if (k == 0) return m_busy ? (mode == 1 ? "R8 R9 R11" : "R5") : "R2";
    if (m_busy) return "R6";
    if (mode == 0) return "R4";
    return (k == 1) ? "R10" : (k == 2) ? "R7" : "R11";
  endfunction

  initial begin
    #(CLK_P * 200000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    chk("R13 err after reset", cmp_err, 1'b0);
    probe(0, 1'b1, "R13 data ready after reset");
    probe(3, 1'b1, "R13 sync ready after reset");

    for (int mode = 0; mode < 2; mode++) begin
      for (int n = 0; n <= MAXC; n++) begin
        for (int p = 0; p < 4; p++) begin
          do_reset();
          rc_mode = mode[0];
          for (int i = 0; i < n; i++) begin
            issue(0);
            m_cnt++;
          end
          if (p != 0) begin
            logic acc;
            acc = (mode == 1 && p == 1) || n == 0;
            probe(p, acc, tag_of(mode, p));
            if (acc) begin
              issue(p);
              m_busy = 1; m_kind = p;
            end
          end
          for (int k = 0; k < 4; k++) probe(k, exp_rdy(mode, k), tag_of(mode, k));
          if (m_busy) begin
            sync_done = 1'b1; cyc(); sync_done = 1'b0;
            m_busy = 0;
          end
          for (int i = 0; i < n; i++) begin
            data_done = 1'b1; cyc(); data_done = 1'b0;
            m_cnt--;
            chk("R3 no err while draining", cmp_err, 1'b0);
            probe(3, m_cnt == 0, "R1 fence lifts at zero");
            if (mode == 0) probe(0, 1'b1, "R1 data ready after drain step");
          end
          data_done = 1'b1; cyc(); data_done = 1'b0;
          chk("R3 err pulse", cmp_err, 1'b1);
          cyc();
          chk("R3 err one cycle", cmp_err, 1'b0);
          probe(3, 1'b1, "R3 count stays zero");
        end
      end
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule